// File: doc/BRIEF.md
# Translation Buffer with Checked Page Invalidation

This block is a small fully associative translation cache that maps virtual page numbers to physical page numbers. A combinational lookup port returns a hit flag and the physical page for any virtual page number. A fill port installs translations. When the page is already cached, the fill updates that entry in place. Otherwise it writes the next slot of a round-robin pointer.

A page-invalidate command port takes a full virtual address together with the issuer's privilege level, a register-operand flag, a lock-prefix flag and a 64-bit-mode flag. The block checks these inputs in a fixed priority order before it touches any entry. A faulting or no-op request leaves the array unchanged. A good request removes the entry for the 4 KiB page that contains the address. Every request gets a one-cycle-later response that carries a 2-bit outcome code. A separate flush input empties the whole array in a single cycle.

Top module: `tlb_pginv`

## Requirements
- R1: When a valid entry holds `lk_vpn`, `lk_hit` is 1 and `lk_ppn` equals that entry's physical page in the same cycle. Otherwise `lk_hit` is 0. No page is ever held by two valid entries.
- R2: A fill of a page that is not cached writes the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one per such fill, wrapping after 8 slots. A fill of a page that is already cached only replaces its physical page and does not move the pointer.
- R3: An invalidate that passes all checks (outcome code 0, done) removes the entry whose page number equals `inv_va[63:12]`. Every other entry is left unchanged.
- R4: An invalidate with `inv_reg_op` or `inv_lock` set changes no entry and reports code 3 (undefined opcode). This check takes priority over the privilege check.
- R5: An invalidate with `inv_cpl` not equal to 0, and neither flag of R4 set, changes no entry and reports code 2 (general protection, error code 0). This check takes priority over the canonical check.
- R6: With `inv_mode64` = 1, an address whose bits 63 down to 47 are not all equal gives code 1 (no-op) and changes no entry. With `inv_mode64` = 0 this check is skipped.
- R7: `inv_rsp_vld` is 1 exactly in the cycle after a cycle with `inv_req` = 1, and `inv_rsp_code` then carries that request's outcome.
- R8: `flush_all` clears every entry at the next clock edge. A fill in the same cycle is dropped and does not move the pointer.
- R9: When a done invalidate and a fill name the same page in the same cycle, the page ends with no valid entry and the pointer does not move. A fill of a different page in that cycle proceeds normally.
- R10: After reset, no entry is valid and `inv_rsp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | 52 | Virtual page number to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 28 | Physical page of the hit entry, 0 on a miss |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 52 | Virtual page number to install |
| fill_ppn | input | 28 | Physical page number to install |
| inv_req | input | 1 | Page-invalidate request |
| inv_va | input | 64 | Virtual address inside the page to remove |
| inv_cpl | input | 2 | Privilege level of the issuer |
| inv_reg_op | input | 1 | Operand was a register |
| inv_lock | input | 1 | Lock prefix present |
| inv_mode64 | input | 1 | Request issued in 64-bit mode |
| flush_all | input | 1 | Clear every entry |
| inv_rsp_vld | output | 1 | Invalidate response strobe |
| inv_rsp_code | output | 2 | 0 done, 1 no-op, 2 GP fault, 3 UD fault |

## Verification
The hardest situations to reach are collisions within a single cycle. These include an invalidate and a fill naming the same page, a flush arriving together with a fill, and a fill landing in the very slot that a simultaneous invalidate empties. Directed steps set up each collision after the round-robin pointer has been walked past a wrap. A long random phase then draws pages from a narrow range of 16, so hits, in-place updates and collisions recur often. A queue-free behavioural model in the bench predicts every response and every lookup on each clock.

// File: rtl/tlb_pginv_pkg.sv
// Shared types for the page-invalidate translation buffer.
// Assumes 2-bit outcome encoding consumed by the fault-delivery logic.
package tlb_pginv_pkg;
    typedef enum logic [1:0] {
        INV_DONE  = 2'd0,
        INV_NOOP  = 2'd1,
        INV_GP    = 2'd2,
        INV_UD    = 2'd3
    } inv_code_e;
endpackage

// File: rtl/tlb_pginv_classify.sv
// Classifies a page-invalidate request into an outcome code.
// Priority: register operand / lock prefix, then privilege, then canonical form.
// Assumes the canonical range is bits VA_W-1 down to CANON_MSB.
module tlb_pginv_classify
    import tlb_pginv_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int CANON_MSB = 47
) (
    input  logic            req,
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      cpl,
    input  logic            reg_op,
    input  logic            lock,
    input  logic            mode64,
    output inv_code_e       code,
    output logic            kill
);
    localparam int HI_W = VA_W - CANON_MSB;

    logic [HI_W-1:0] hi_bits;
    logic            canonical;

    assign hi_bits   = va[VA_W-1:CANON_MSB];
    assign canonical = (&hi_bits) | ~(|hi_bits);

    // Outcome selection in fixed priority order.
    always_comb begin
        if (reg_op || lock)            code = INV_UD;
        else if (cpl != 2'd0)          code = INV_GP;
        else if (mode64 && !canonical) code = INV_NOOP;
        else                           code = INV_DONE;
    end

    assign kill = req && (code == INV_DONE);
endmodule

// File: rtl/tlb_pginv_store.sv
// Fully associative entry array: combinational lookup, fill with
// in-place update or round-robin allocation, single-page kill, full flush.
// Assumes a kill and a fill of the same page in one cycle drop the fill.
module tlb_pginv_store #(
    parameter int N     = 8,
    parameter int VPN_W = 52,
    parameter int PPN_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             kill_en,
    input  logic [VPN_W-1:0] kill_vpn,
    input  logic             flush_all
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    logic [N-1:0]     valid_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PPN_W-1:0] ppn_q [N];
    logic [PTR_W-1:0] ptr_q;
    logic [N-1:0]     lk_match, fill_match, kill_match;
    logic             fill_hit, fill_go;

    // Per-entry tag comparators.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign lk_match[i]   = valid_q[i] && (vpn_q[i] == lk_vpn);
        assign fill_match[i] = valid_q[i] && (vpn_q[i] == fill_vpn);
        assign kill_match[i] = valid_q[i] && (vpn_q[i] == kill_vpn);
    end

    // Lookup: OR-reduce the physical page of the matching entry.
    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < N; i++)
            if (lk_match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
    assign lk_hit = |lk_match;

    assign fill_hit = |fill_match;
    assign fill_go  = fill_en && !flush_all && !(kill_en && kill_vpn == fill_vpn);

    // Entry state update: reset, flush, kill, then fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < N; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else if (flush_all) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < N; i++)
                if (kill_en && kill_match[i]) valid_q[i] <= 1'b0;
            if (fill_go) begin
                if (fill_hit) begin
                    for (int i = 0; i < N; i++)
                        if (fill_match[i]) ppn_q[i] <= fill_ppn;
                end else begin
                    valid_q[ptr_q] <= 1'b1;
                    vpn_q[ptr_q]   <= fill_vpn;
                    ppn_q[ptr_q]   <= fill_ppn;
                    ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
                end
            end
        end
    end

    // R1: a page is never held twice.
    a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8: flush empties the array.
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R10: nothing valid right after reset.
    a_r10_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R3: a killed page leaves its entry invalid.
    for (genvar i = 0; i < N; i++) begin : g_kill_chk
        a_r3_kill_removes: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_en && kill_match[i] && !(ptr_q == PTR_W'(i) && fill_go && !fill_hit))
            |=> !valid_q[i]);
    end
endmodule

// File: rtl/tlb_pginv.sv
// Top level: translation buffer with a checked page-invalidate port.
// Response is registered one cycle after the request; entries change
// at the same edge. Assumes 4 KiB pages.
module tlb_pginv
    import tlb_pginv_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PAGE_BITS  = 12,
    parameter int PPN_W      = 28,
    parameter int N_ENTRIES  = 8,
    parameter int CANON_MSB  = 47,
    parameter int VPN_W      = VA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             inv_req,
    input  logic [VA_W-1:0]  inv_va,
    input  logic [1:0]       inv_cpl,
    input  logic             inv_reg_op,
    input  logic             inv_lock,
    input  logic             inv_mode64,
    input  logic             flush_all,
    output logic             inv_rsp_vld,
    output logic [1:0]       inv_rsp_code
);
    inv_code_e        cls_code;
    logic             kill_en;
    logic [VPN_W-1:0] kill_vpn;

    assign kill_vpn = inv_va[VA_W-1:PAGE_BITS];

    tlb_pginv_classify #(.VA_W(VA_W), .CANON_MSB(CANON_MSB)) u_cls (
        .req    (inv_req),
        .va     (inv_va),
        .cpl    (inv_cpl),
        .reg_op (inv_reg_op),
        .lock   (inv_lock),
        .mode64 (inv_mode64),
        .code   (cls_code),
        .kill   (kill_en)
    );

    tlb_pginv_store #(.N(N_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .kill_en   (kill_en),
        .kill_vpn  (kill_vpn),
        .flush_all (flush_all)
    );

    // Response register: strobe and outcome one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_rsp_vld  <= 1'b0;
            inv_rsp_code <= 2'd0;
        end else begin
            inv_rsp_vld  <= inv_req;
            inv_rsp_code <= inv_req ? cls_code : 2'd0;
        end
    end

    // R7: every request answered next cycle.
    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> inv_rsp_vld);
    // R7: no response without a request.
    a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_req |=> !inv_rsp_vld);
    // R4: register operand or lock prefix gives UD.
    a_r4_ud_code: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && (inv_reg_op || inv_lock)) |=> (inv_rsp_code == 2'd3));
    // R5: nonzero privilege without UD causes gives GP.
    a_r5_gp_code: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_reg_op && !inv_lock && inv_cpl != 2'd0) |=> (inv_rsp_code == 2'd2));
    // R6: non-canonical in 64-bit mode, no fault causes: no-op.
    a_r6_noncanon_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_reg_op && !inv_lock && inv_cpl == 2'd0 && inv_mode64
         && !(&inv_va[VA_W-1:CANON_MSB]) && (|inv_va[VA_W-1:CANON_MSB]))
        |=> (inv_rsp_code == 2'd1));
endmodule

// File: tb/tlb_pginv_tb.sv
module tlb_pginv_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [51:0] lk_vpn;
    logic        lk_hit;
    logic [27:0] lk_ppn;
    logic        fill_en;
    logic [51:0] fill_vpn;
    logic [27:0] fill_ppn;
    logic        inv_req;
    logic [63:0] inv_va;
    logic [1:0]  inv_cpl;
    logic        inv_reg_op, inv_lock, inv_mode64, flush_all;
    logic        inv_rsp_vld;
    logic [1:0]  inv_rsp_code;

    tlb_pginv u_dut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .inv_req(inv_req), .inv_va(inv_va), .inv_cpl(inv_cpl),
        .inv_reg_op(inv_reg_op), .inv_lock(inv_lock), .inv_mode64(inv_mode64),
        .flush_all(flush_all), .inv_rsp_vld(inv_rsp_vld), .inv_rsp_code(inv_rsp_code)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_valid [N];
    logic [51:0] m_vpn [N];
    logic [27:0] m_ppn [N];
    int          m_ptr;
    bit          e_vld;
    logic [1:0]  e_code;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_code(logic [63:0] va, logic [1:0] cpl,
                                            logic rg, logic lk, logic m64);
        logic [16:0] hi;
        hi = va[63:47];
        if (rg || lk) return 2'd3;
        if (cpl != 0) return 2'd2;
        if (m64 && !(hi == '0 || hi == '1)) return 2'd1;
        return 2'd0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_ptr = 0; e_vld = 0; e_code = 0;
    endtask

    // Apply one clock of stimulus to the model, from the requirements.
    task automatic model_step();
        logic [1:0] c;
        bit kill, hit;
        logic [51:0] kv;
        c = ref_code(inv_va, inv_cpl, inv_reg_op, inv_lock, inv_mode64);
        kill = inv_req && (c == 2'd0);
        kv = inv_va[63:12];
        e_vld = inv_req;
        e_code = inv_req ? c : 2'd0;
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            return;
        end
        if (kill)
            for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == kv) m_valid[i] = 0;
        if (fill_en && !(kill && kv == fill_vpn)) begin
            hit = 0;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_vpn[i] == fill_vpn) begin m_ppn[i] = fill_ppn; hit = 1; end
            if (!hit) begin
                m_valid[m_ptr] = 1; m_vpn[m_ptr] = fill_vpn; m_ppn[m_ptr] = fill_ppn;
                m_ptr = (m_ptr + 1) % N;
            end
        end
    endtask

    task automatic probe(string req, logic [51:0] v);
        bit h; logic [27:0] p;
        h = 0; p = '0;
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) begin h = 1; p = m_ppn[i]; end
        lk_vpn = v;
        #1;
        check({req, " lookup hit"}, 64'(lk_hit), 64'(h));
        check({req, " lookup ppn"}, 64'(lk_ppn), 64'(p));
    endtask

    task automatic idle_inputs();
        fill_en = 0; inv_req = 0; inv_reg_op = 0; inv_lock = 0; flush_all = 0;
    endtask

    // One clock: inputs already driven; update model at edge, then compare.
    task automatic step(string req, logic [51:0] pv);
        @(posedge clk);
        model_step();
        #2;
        idle_inputs();
        check({req, " rsp_vld"}, 64'(inv_rsp_vld), 64'(e_vld));
        if (e_vld) check({req, " rsp_code"}, 64'(inv_rsp_code), 64'(e_code));
        probe(req, pv);
        probe(req, fill_vpn);
        probe(req, inv_va[63:12]);
    endtask

    task automatic do_fill(string req, logic [51:0] v, logic [27:0] p);
        fill_en = 1; fill_vpn = v; fill_ppn = p;
        step(req, v);
    endtask

    task automatic do_inv(string req, logic [63:0] va, logic [1:0] cpl,
                          logic rg, logic lk, logic m64);
        inv_req = 1; inv_va = va; inv_cpl = cpl; inv_reg_op = rg; inv_lock = lk; inv_mode64 = m64;
        step(req, va[63:12]);
    endtask

    task automatic probe_all(string req);
        for (int v = 'h10; v < 'h1c; v++) probe(req, 52'(v));
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs();
        lk_vpn = '0; fill_vpn = '0; fill_ppn = '0; inv_va = '0; inv_cpl = 0; inv_mode64 = 1;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        check("R10 reset rsp_vld", 64'(inv_rsp_vld), 0);
        probe("R10", 52'h10);

        // R2: 10 fills walk and wrap the pointer
        for (int i = 0; i < 10; i++) do_fill("R2", 52'('h10 + i), 28'('h100 + i));
        probe_all("R2 wrap");
        do_fill("R2 inplace", 52'h13, 28'hABC);
        do_fill("R2 after inplace", 52'h30, 28'h330);
        probe_all("R2");
        probe("R2", 52'h30);

        // R3: good invalidate with offset
        do_inv("R3", 64'h0000_0000_0001_3FFC, 0, 0, 0, 1);
        probe_all("R3 others");
        // R4: register operand, lock, priority over GP
        do_inv("R4 reg", 64'h0000_0000_0001_4000, 0, 1, 0, 1);
        do_inv("R4 lock", 64'h0000_0000_0001_4000, 0, 0, 1, 1);
        do_inv("R4 prio", 64'h0000_0000_0001_4000, 3, 1, 0, 1);
        // R5: privilege, priority over canonical
        do_inv("R5 cpl", 64'h0000_0000_0001_4000, 3, 0, 0, 1);
        do_inv("R5 cpl1", 64'h0000_0000_0001_5000, 1, 0, 0, 1);
        do_inv("R5 prio", 64'h8000_0000_0001_4000, 3, 0, 0, 1);
        probe_all("R4 R5 unchanged");
        // R6: non-canonical
        do_inv("R6 noncanon", 64'h0000_8000_0001_4000, 0, 0, 0, 1);
        do_inv("R6 legacy", 64'h0000_8000_0001_4000, 0, 0, 0, 0);
        do_inv("R6 legacy kill", 64'h0000_0000_0001_4123, 0, 0, 0, 0);
        do_fill("R6 high", 52'hFFFF_8000_0000_5, 28'h555);
        do_inv("R6 canon high", 64'hFFFF_8000_0000_5000, 0, 0, 0, 1);
        probe_all("R6");

        // R9: collision same page, then different page
        fill_en = 1; fill_vpn = 52'h15; fill_ppn = 28'h777;
        do_inv("R9 same", 64'h0000_0000_0001_5000, 0, 0, 0, 1);
        fill_en = 1; fill_vpn = 52'h40; fill_ppn = 28'h440;
        do_inv("R9 diff", 64'h0000_0000_0001_6000, 0, 0, 0, 1);
        do_fill("R9 ptr", 52'h41, 28'h441);
        probe_all("R9");

        // R8: flush with fill
        flush_all = 1; fill_en = 1; fill_vpn = 52'h50; fill_ppn = 28'h5;
        step("R8", 52'h50);
        probe_all("R8 empty");
        do_fill("R8 ptr", 52'h51, 28'h51);

        // Random mix over a narrow page range
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            fill_en = ($urandom_range(0, 2) != 0);
            fill_vpn = 52'($urandom_range(0, 15));
            fill_ppn = 28'($urandom);
            inv_req = ($urandom_range(0, 1) != 0);
            inv_va = {($urandom_range(0, 9) == 0) ? 16'h8000 : 16'h0000,
                      36'($urandom_range(0, 15)), 12'($urandom)};
            inv_cpl = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            inv_reg_op = ($urandom_range(0, 15) == 0);
            inv_lock = ($urandom_range(0, 15) == 0);
            inv_mode64 = ($urandom_range(0, 4) != 0);
            flush_all = (r < 2);
            step("R1 R3 R7 R9 random", 52'($urandom_range(0, 15)));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule